// File: doc/BRIEF.md
# Display RAM Processor Bus Port

This block is the processor side of a graphic LCD column driver. An external processor reaches it over an 8-bit data bus, an enable strobe E, a read/write line and a data/instruction line. Three chip selects gate every access. The block turns these asynchronous bus cycles into accesses on a synchronous display RAM port. It also keeps the RAM address counter, which steps by one after every data access.

Writes go through an input register. Reads come from an output register that is refilled only when a data read ends. Because of this, the first read after the address changes returns the byte from the previous read. Software therefore issues one dummy read before real data appears. All bus inputs are first brought into the core clock domain through a synchronizer chain. Every action is triggered by the detected falling edge of E.

Instruction decoding in this block is limited to address set. Every other instruction byte is handed on as a one-cycle strobe. The status byte comes in from outside and is only driven out.

Top module: `dispBusIf`

## Requirements
- R1: After reset the address counter is 0, the output register holds 0x00, `ramWrEn` and `busOe` are low, and no instruction strobe is pending.
- R2: An access takes effect only when `csN1`=0, `csN2`=0 and `cs3`=1. With any other chip-select combination, an E cycle changes no RAM word, no address, no register and no strobe, and does not enable the bus drivers.
- R3: The access type is chosen by `dataSel` (D/I) and `rdWr` (R/W): D/I=1,R/W=0 is a data write; D/I=1,R/W=1 is a data read; D/I=0,R/W=0 is an instruction write; D/I=0,R/W=1 is a status read. At most one access type is active per E cycle.
- R4: On a data write, the bus byte present when E falls is latched into the input register. It is then stored into RAM at the current address with exactly one `ramWrEn` pulse, and the address then increments by 1.
- R5: On a data read, the output register is driven on the bus while E is high. After E falls, the RAM word at the current address is loaded into the output register, and the address increments by 1.
- R6: Only data reads change the output register. Address set, other instructions, writes and status reads leave it unchanged, so the first read after an address set returns stale data.
- R7: An instruction byte whose bits [7:6] are `01` loads bits [5:0] into the address counter. Any other instruction byte leaves the address unchanged and produces a one-cycle `instStb` with the byte on `instByte`.
- R8: The address counter wraps from 63 to 0, both on writes and on reads.
- R9: `busOe` is high only while the chip is selected, R/W=1 and E is high. During a status read, `busOut` carries `statusIn`.
- R10: `ramWrEn` is a single-cycle pulse, never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset, independent of chip selects |
| enIn | input | 1 | Bus enable strobe E, actions on its falling edge |
| rdWr | input | 1 | 1 = read, 0 = write |
| dataSel | input | 1 | 1 = display data, 0 = instruction/status |
| csN1 | input | 1 | Chip select, active low |
| csN2 | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| busIn | input | 8 | Data bus input half (bit 7 MSB) |
| busOut | output | 8 | Data bus output half |
| busOe | output | 1 | Data bus driver enable |
| statusIn | input | 8 | Status byte supplied by the status logic |
| ramAddr | output | 6 | Display RAM address |
| ramWrEn | output | 1 | Display RAM write strobe |
| ramWrData | output | 8 | Display RAM write data |
| ramRdEn | output | 1 | Display RAM read request |
| ramRdData | input | 8 | Display RAM read data, one cycle after the address |
| instStb | output | 1 | Strobe for an instruction other than address set |
| instByte | output | 8 | Instruction byte that goes with `instStb` |

## Verification
The assertions check the following on every cycle: the write strobe stays one cycle wide, at most one access strobe is active, and the bus drivers are enabled only when a read was requested while E was high. They also check that each RAM write or read advances the address by exactly one, modulo 64. Only the bench scenarios can show the end-to-end data path. That covers the dummy-read lag after an address set, the bytes landing at the right addresses across the 63-to-0 wrap, and deselected cycles leaving the RAM contents and address untouched.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;
  localparam int DISP_DATA_W = 8;
  localparam int DISP_ADDR_W = 6;
  localparam logic [1:0] ADDR_SET_OP = 2'b01;

  // Sampled bus pins; cs[0]=csN1, cs[1]=csN2, cs[2]=cs3
  typedef struct packed {
    logic en;
    logic rw;
    logic di;
    logic [2:0] cs;
    logic [DISP_DATA_W-1:0] data;
  } busSample_t;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic dataWr;
    logic dataRd;
    logic instWr;
  } accStrb_t;
endpackage

// File: rtl/dispBusCtrl.sv
module dispBusCtrl
  import disp_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enIn,
  input  logic                   rdWr,
  input  logic                   dataSel,
  input  logic                   csN1,
  input  logic                   csN2,
  input  logic                   cs3,
  input  logic [DISP_DATA_W-1:0] busIn,
  output accStrb_t               strb,
  output logic [DISP_DATA_W-1:0] latchByte,
  output logic                   busDrive,
  output logic                   busDi
);
  localparam int LAST = SYNC_STAGES - 1;

  busSample_t rawS;
  busSample_t syncQ [SYNC_STAGES];
  busSample_t cur;
  logic       enPrev;
  logic       enFall;
  logic       chipSel;

  assign rawS = '{en: enIn, rw: rdWr, di: dataSel, cs: {cs3, csN2, csN1}, data: busIn};

  // Synchronizer chain for all bus pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= rawS;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign cur     = syncQ[LAST];
  assign chipSel = !cur.cs[0] && !cur.cs[1] && cur.cs[2];
  assign enFall  = enPrev && !cur.en;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= cur.en;
  end

  // Access decode on the E falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb      <= '0;
      latchByte <= '0;
    end else begin
      strb <= '0;
      if (enFall && chipSel) begin
        latchByte <= cur.data;
        unique case ({cur.di, cur.rw})
          2'b10:   strb.dataWr <= 1'b1;
          2'b11:   strb.dataRd <= 1'b1;
          2'b00:   strb.instWr <= 1'b1;
          default: strb        <= '0;
        endcase
      end
    end
  end

  assign busDrive = chipSel && cur.rw && cur.en;
  assign busDi    = cur.di;
endmodule

// File: rtl/dispBusDatapath.sv
module dispBusDatapath
  import disp_bus_pkg::*;
#(
  parameter int ADDR_W = DISP_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  accStrb_t               strb,
  input  logic [DISP_DATA_W-1:0] latchByte,
  input  logic                   busDrive,
  input  logic                   busDi,
  input  logic [DISP_DATA_W-1:0] statusIn,
  input  logic [DISP_DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic                   ramWrEn,
  output logic [DISP_DATA_W-1:0] ramWrData,
  output logic                   ramRdEn,
  output logic [DISP_DATA_W-1:0] busOut,
  output logic                   busOe,
  output logic                   instStb,
  output logic [DISP_DATA_W-1:0] instByte
);
  logic [ADDR_W-1:0]      addrQ;
  logic [DISP_DATA_W-1:0] inReg;
  logic [DISP_DATA_W-1:0] outReg;
  logic                   wrPend;
  logic                   rdPend;
  logic                   isAddrSet;

  assign isAddrSet = (latchByte[DISP_DATA_W-1 -: 2] == ADDR_SET_OP);

  // Address counter: set, or step after each RAM access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strb.instWr && isAddrSet) begin
      addrQ <= latchByte[ADDR_W-1:0];
    end else if (wrPend || rdPend) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  // Input register and write pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      wrPend <= 1'b0;
    end else begin
      wrPend <= strb.dataWr;
      if (strb.dataWr) inReg <= latchByte;
    end
  end

  // Output register refilled only by data reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      rdPend <= 1'b0;
    end else begin
      rdPend <= strb.dataRd;
      if (rdPend) outReg <= ramRdData;
    end
  end

  // Hand-off of non-address instructions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instStb  <= 1'b0;
      instByte <= '0;
    end else begin
      instStb <= strb.instWr && !isAddrSet;
      if (strb.instWr && !isAddrSet) instByte <= latchByte;
    end
  end

  assign ramAddr   = addrQ;
  assign ramWrEn   = wrPend;
  assign ramWrData = inReg;
  assign ramRdEn   = strb.dataRd;
  assign busOe     = busDrive;
  assign busOut    = busDi ? outReg : statusIn;
endmodule

// File: rtl/dispBusIf.sv
module dispBusIf
  import disp_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = DISP_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enIn,
  input  logic                   rdWr,
  input  logic                   dataSel,
  input  logic                   csN1,
  input  logic                   csN2,
  input  logic                   cs3,
  input  logic [DISP_DATA_W-1:0] busIn,
  output logic [DISP_DATA_W-1:0] busOut,
  output logic                   busOe,
  input  logic [DISP_DATA_W-1:0] statusIn,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic                   ramWrEn,
  output logic [DISP_DATA_W-1:0] ramWrData,
  output logic                   ramRdEn,
  input  logic [DISP_DATA_W-1:0] ramRdData,
  output logic                   instStb,
  output logic [DISP_DATA_W-1:0] instByte
);
  accStrb_t               strb;
  logic [DISP_DATA_W-1:0] latchByte;
  logic                   busDrive;
  logic                   busDi;

  dispBusCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .rdWr(rdWr), .dataSel(dataSel),
    .csN1(csN1), .csN2(csN2), .cs3(cs3), .busIn(busIn),
    .strb(strb), .latchByte(latchByte), .busDrive(busDrive), .busDi(busDi)
  );

  dispBusDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .latchByte(latchByte),
    .busDrive(busDrive), .busDi(busDi), .statusIn(statusIn),
    .ramRdData(ramRdData), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .ramWrData(ramWrData), .ramRdEn(ramRdEn), .busOut(busOut),
    .busOe(busOe), .instStb(instStb), .instByte(instByte)
  );
endmodule

// File: rtl/dispBusIfChk.sv
module dispBusIfChk
  import disp_bus_pkg::*;
#(
  parameter int ADDR_W = DISP_ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              enIn,
  input logic              rdWr,
  input logic              busOe,
  input logic              ramWrEn,
  input logic              ramRdEn,
  input logic              instStb,
  input logic [ADDR_W-1:0] ramAddr,
  input accStrb_t          strb
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> !ramWrEn);  // R10

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));  // R3

  AST_WR_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> $past(strb.dataWr));  // R4

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(ramWrEn) |-> ramAddr == $past(ramAddr) + 1'b1);  // R8

  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(ramRdEn, 2) |-> ramAddr == $past(ramAddr, 2) + 1'b1);  // R5

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> ($past(rdWr, 2) && $past(enIn, 2)));  // R9

  AST_INST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    instStb |-> !ramWrEn);  // R7
endmodule

bind dispBusIf dispBusIfChk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .enIn(enIn), .rdWr(rdWr), .busOe(busOe),
  .ramWrEn(ramWrEn), .ramRdEn(ramRdEn), .instStb(instStb),
  .ramAddr(ramAddr), .strb(strb)
);

// File: tb/test_dispBusIf.sv
`timescale 1ns/1ps
module test_dispBusIf;
  logic       clk = 0;
  logic       rstN = 0;
  logic       enIn = 0, rdWr = 0, dataSel = 0;
  logic       csN1 = 1, csN2 = 1, cs3 = 0;
  logic [7:0] busIn = 0, statusIn = 0;
  logic [7:0] busOut, ramWrData, ramRdData, instByte;
  logic       busOe, ramWrEn, ramRdEn, instStb;
  logic [5:0] ramAddr;

  logic [7:0] mem  [64];
  logic [7:0] gold [64];
  logic [5:0] expAddr = 0;
  logic [7:0] expOut = 0;
  int errors = 0, checks = 0;
  int wrCnt = 0, instCnt = 0, expWrCnt = 0, expInstCnt = 0;
  logic [7:0] lastInst;
  bit done = 0;

  always #5 clk = ~clk;

  dispBusIf i_dispBusIf (
    .clk(clk), .rstN(rstN), .enIn(enIn), .rdWr(rdWr), .dataSel(dataSel),
    .csN1(csN1), .csN2(csN2), .cs3(cs3), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .statusIn(statusIn), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .ramWrData(ramWrData), .ramRdEn(ramRdEn), .ramRdData(ramRdData),
    .instStb(instStb), .instByte(instByte)
  );

  // Synchronous RAM model
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= ramWrData;
    ramRdData <= mem[ramAddr];
  end

  always @(posedge clk) begin
    if (ramWrEn) wrCnt <= wrCnt + 1;
    if (instStb) begin instCnt <= instCnt + 1; lastInst <= instByte; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle; sel picks a chip-select pattern (0 = selected)
  task automatic busCycle(input bit rw, input bit di, input logic [7:0] d, input int sel);
    bit chosen;
    @(negedge clk);
    rdWr = rw; dataSel = di; busIn = d;
    statusIn = 8'($urandom);
    case (sel)
      0: begin csN1 = 0; csN2 = 0; cs3 = 1; end
      1: begin csN1 = 1; csN2 = 0; cs3 = 1; end
      2: begin csN1 = 0; csN2 = 1; cs3 = 1; end
      default: begin csN1 = 0; csN2 = 0; cs3 = 0; end
    endcase
    chosen = (sel == 0);
    repeat (3) @(negedge clk);
    check(!busOe, "R9 oe low before E", busOe, 0);
    enIn = 1;
    repeat (6) @(negedge clk);
    if (rw && chosen) begin
      check(busOe, "R9 oe during read", busOe, 1);
      if (di) check(busOut == expOut, "R5 output register on bus", busOut, expOut);
      else    check(busOut == statusIn, "R9 status on bus", busOut, statusIn);
    end else begin
      check(!busOe, "R2 R9 oe stays low", busOe, 0);
    end
    enIn = 0;
    if (chosen) begin
      case ({di, rw})
        2'b10: begin gold[expAddr] = d; expAddr++; expWrCnt++; end
        2'b11: begin expOut = gold[expAddr]; expAddr++; end
        2'b00: if (d[7:6] == 2'b01) expAddr = d[5:0];
               else expInstCnt++;
        default: ;
      endcase
    end
    repeat (10) @(negedge clk);
    check(wrCnt == expWrCnt, "R4 R2 write count", wrCnt, expWrCnt);
    check(instCnt == expInstCnt, "R7 instruction strobe count", instCnt, expInstCnt);
    if (chosen && !di && !rw && d[7:6] != 2'b01)
      check(lastInst == d, "R7 instruction byte", lastInst, d);
  endtask

  task automatic setAddr(input logic [5:0] a);
    busCycle(0, 0, {2'b01, a}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 64; i++) begin mem[i] = 0; gold[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busOe && !ramWrEn && !instStb, "R1 outputs idle in reset", {busOe, ramWrEn, instStb}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(ramAddr == 0, "R1 address zero", ramAddr, 0);
    busCycle(1, 1, 0, 0);  // R1: first read shows 0x00 output register

    // R4/R5/R6: write, set address, dummy read, real read
    setAddr(6'd10);
    busCycle(0, 1, 8'hA5, 0);
    busCycle(0, 1, 8'h3C, 0);
    setAddr(6'd10);
    busCycle(1, 1, 0, 0);            // R6: dummy read shows stale value
    busCycle(1, 1, 0, 0);            // R5: shows A5
    check(expOut == 8'h3C, "R5 model sanity", expOut, 8'h3C);
    busCycle(1, 1, 0, 0);

    // R2: deselected writes and reads do nothing
    for (int s = 1; s < 4; s++) busCycle(0, 1, 8'hFF, s);
    for (int s = 1; s < 4; s++) busCycle(0, 0, 8'h41, s);
    for (int s = 1; s < 4; s++) busCycle(1, 1, 0, s);
    setAddr(6'd10);
    busCycle(1, 1, 0, 0);
    busCycle(1, 1, 0, 0);            // R2: still A5

    // R8: wrap from 63 to 0
    setAddr(6'd63);
    busCycle(0, 1, 8'h11, 0);
    busCycle(0, 1, 8'h22, 0);
    setAddr(6'd63);
    busCycle(1, 1, 0, 0);
    busCycle(1, 1, 0, 0);
    busCycle(1, 1, 0, 0);            // R8: shows 0x22 from address 0

    // R7: other instructions leave address alone; R9: status read
    busCycle(0, 0, 8'hC7, 0);
    busCycle(0, 0, 8'h3F, 0);
    busCycle(1, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      int sel;
      logic [7:0] d;
      kind = int'($urandom_range(0, 3));
      sel  = ($urandom_range(0, 9) < 8) ? 0 : int'($urandom_range(1, 3));
      d    = 8'($urandom);
      case (kind)
        0: busCycle(0, 1, d, sel);
        1: busCycle(1, 1, 0, sel);
        2: begin
             if ($urandom_range(0, 1) == 1) d[7:6] = 2'b01;
             else if (d[7:6] == 2'b01) d[7] = 1'b1;
             busCycle(0, 0, d, sel);
           end
        default: busCycle(1, 0, 0, sel);
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule